// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Sequencer

This block loads a downstream FPGA through its slave-serial configuration pins. A single start pulse launches a fixed sequence. First a termination pattern on four auxiliary pins stops whatever design the target is running. Then the program line is pulsed low, and the block waits for the target to raise its init line. Finally the configuration bitstream, supplied as bytes over a valid/ready stream, is clocked out one bit at a time on the data pin.

All pin changes happen on a paced update tick. The tick comes from a clock-enable divider set by the system clock and the wanted update rate (750 k updates per second by default). The clock pin passes through an inverting level shifter before it reaches the target. A high level on the clock output is therefore idle from the target's point of view, and the target samples data when the output falls.

If the init line stays low for too long, the whole termination-and-program sequence is attempted again, up to a parameter count. After that the block reports a timeout. It reports completion once the byte flagged as last has been shifted out.

Top module: `cfg_serial_loader`

## Requirements
- R1: After synchronous reset the pins rest with the clock output high, the program output high, the data output low and all four auxiliary outputs low. Done, timeout and byte-ready are all low.
- R2: A start pulse is taken only while the block is idle, and taking it clears done and timeout. A start pulse during a download has no effect on the pin sequence.
- R3: The termination pattern lasts 32 updates: an 8-update pattern sent four times. Auxiliary bit 3 is high throughout and bit 2 is low throughout. Within each 8-update pattern, positions 2, 4 and 6 drive bit 1 high and bit 0 low (aux = 1010). Every other position drives bit 0 high and bit 1 low (aux = 1001).
- R4: Right after the pattern, the program output is low for PROG_TICKS updates while the auxiliary outputs are low.
- R5: After the program pulse, the init input (passed through a two-stage synchronizer) is polled once per update. A high level moves the block to loading. INIT_LIMIT consecutive low polls fail the attempt.
- R6: A failed attempt restarts at the termination pattern, up to ATTEMPTS attempts in total. When the last attempt fails, timeout goes high and the block returns to idle with resting pins.
- R7: Each configuration bit takes two updates, most significant bit first. In the first update the data output carries the bit and the clock output is high. In the second update the data output is unchanged and the clock output is low.
- R8: Byte-ready is high only in the loading state and only in a cycle that carries an update tick. A byte is taken when valid and ready are both high. Each loading phase lasts one resting update, before the first byte and between bytes.
- R9: When the byte marked by byte_last_i finishes its eighth bit, done goes high and the pins return to rest.
- R10: Pin outputs change only on an update tick. They hold for the full divider period between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a configuration sequence (taken only when idle) |
| byte_data_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | Bitstream byte is present |
| byte_last_i | input | 1 | Present byte is the final one |
| byte_ready_o | output | 1 | Block takes the byte in this cycle if valid |
| init_i | input | 1 | Target's init line (asynchronous) |
| cclk_o | output | 1 | Configuration clock, inverted on the board |
| prog_o | output | 1 | Program line, pulsed low |
| din_o | output | 1 | Configuration data |
| aux_o | output | 4 | Termination lines: bit0 line A, bit1 line B, bit2 spare, bit3 hold |
| done_o | output | 1 | Last byte has been shifted out |
| timeout_o | output | 1 | All attempts failed waiting for init |

## Verification
A corrupted step or attempt counter shows up at the pins within one update period. The termination pattern would be cut short, its line A/line B order would shift, or a retry would begin or end one pass early. A bad bit index or phase flag changes the data or clock level at the very next sample. A wrong state decode gives byte-ready in a cycle with no tick. Sampling each update both at its start and at its middle, over full runs that succeed, time out and recover on retry, exposes these faults within a few hundred clocks.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int KILL_LEN   = 8;
    localparam int KILL_REPS  = 4;
    localparam int KILL_TOTAL = KILL_LEN * KILL_REPS;
    localparam int BYTE_BITS  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_KILL,
        ST_PROG,
        ST_WAIT,
        ST_LOAD,
        ST_SHIFT
    } seq_state_e;

    typedef struct packed {
        logic       cclk;
        logic       prog;
        logic       din;
        logic [3:0] aux;
    } pin_vec_t;

    localparam pin_vec_t PINS_REST = '{cclk: 1'b1, prog: 1'b1, din: 1'b0, aux: 4'b0000};

    // Hold line high always; line B at even non-zero positions, line A elsewhere.
    function automatic logic [3:0] kill_aux(input logic [2:0] idx);
        if (idx != 3'd0 && idx[0] == 1'b0)
            return 4'b1010;
        return 4'b1001;
    endfunction

endpackage

// File: rtl/cfgl_tick.sv
module cfgl_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            localparam int TW = $clog2(DIV);
            logic [TW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || cnt == TW'(DIV - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == TW'(DIV - 1));

            p_tick_period_r10: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
    import cfgl_pkg::*;
#(
    parameter int PROG_TICKS = 4,
    parameter int INIT_LIMIT = 1000,
    parameter int ATTEMPTS   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start_i,
    input  logic [7:0] byte_data_i,
    input  logic       byte_valid_i,
    input  logic       byte_last_i,
    output logic       byte_ready_o,
    input  logic       init_i,
    output pin_vec_t   pins_o,
    output logic       done_o,
    output logic       timeout_o
);
    localparam int KW   = $clog2(KILL_TOTAL);
    localparam int CMAX = (PROG_TICKS > INIT_LIMIT) ? PROG_TICKS : INIT_LIMIT;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int AW   = $clog2(ATTEMPTS + 1);
    localparam int BW   = $clog2(BYTE_BITS);

    seq_state_e    state;
    logic [KW-1:0] step;
    logic [CW-1:0] cnt;
    logic [AW-1:0] att;
    logic [7:0]    shreg;
    logic [BW-1:0] bitn;
    logic          phase;
    logic          last_q;
    logic          done_q;
    logic          tmo_q;
    logic [1:0]    init_sync;
    logic          init_s;
    logic          accept;

    always_ff @(posedge clk) begin
        if (rst) init_sync <= 2'b00;
        else     init_sync <= {init_sync[0], init_i};
    end
    assign init_s = init_sync[1];

    assign byte_ready_o = (state == ST_LOAD) && tick;
    assign accept       = byte_ready_o && byte_valid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            step   <= '0;
            cnt    <= '0;
            att    <= '0;
            shreg  <= '0;
            bitn   <= '0;
            phase  <= 1'b0;
            last_q <= 1'b0;
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    done_q <= 1'b0;
                    tmo_q  <= 1'b0;
                    att    <= '0;
                    state  <= ST_ARM;
                end
                ST_ARM: if (tick) begin
                    step  <= '0;
                    state <= ST_KILL;
                end
                ST_KILL: if (tick) begin
                    if (step == KW'(KILL_TOTAL - 1)) begin
                        cnt   <= '0;
                        state <= ST_PROG;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                ST_PROG: if (tick) begin
                    if (cnt == CW'(PROG_TICKS - 1)) begin
                        cnt   <= '0;
                        state <= ST_WAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT: if (tick) begin
                    if (init_s) begin
                        state <= ST_LOAD;
                    end else if (cnt == CW'(INIT_LIMIT - 1)) begin
                        if (att == AW'(ATTEMPTS - 1)) begin
                            tmo_q <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            att   <= att + 1'b1;
                            step  <= '0;
                            state <= ST_KILL;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_LOAD: if (accept) begin
                    shreg  <= byte_data_i;
                    last_q <= byte_last_i;
                    bitn   <= '0;
                    phase  <= 1'b0;
                    state  <= ST_SHIFT;
                end
                ST_SHIFT: if (tick) begin
                    if (!phase) begin
                        phase <= 1'b1;
                    end else begin
                        phase <= 1'b0;
                        shreg <= {shreg[6:0], 1'b0};
                        if (bitn == BW'(BYTE_BITS - 1)) begin
                            if (last_q) begin
                                done_q <= 1'b1;
                                state  <= ST_IDLE;
                            end else begin
                                state <= ST_LOAD;
                            end
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pins_o = PINS_REST;
        case (state)
            ST_KILL:  pins_o.aux  = kill_aux(step[2:0]);
            ST_PROG:  pins_o.prog = 1'b0;
            ST_SHIFT: begin
                pins_o.din  = shreg[7];
                pins_o.cclk = ~phase;
            end
            default: ;
        endcase
    end

    assign done_o    = done_q;
    assign timeout_o = tmo_q;

    logic [6:0] pv;
    assign pv = pins_o;

    p_hold_between_ticks_r10: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pv));
    p_ready_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
        byte_ready_o |-> tick);
    p_status_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(done_o && timeout_o));
    p_cclk_low_only_shift_r7: assert property (@(posedge clk) disable iff (rst)
        !pins_o.cclk |-> (pins_o.prog && pins_o.aux == 4'b0000));
    p_prog_quiet_aux_r4: assert property (@(posedge clk) disable iff (rst)
        !pins_o.prog |-> (pins_o.aux == 4'b0000 && pins_o.cclk));
    p_din_held_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(pins_o.cclk) |-> $stable(pins_o.din));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgl_pkg::*;
#(
    parameter int CLK_HZ     = 200_000_000,
    parameter int UPDATE_HZ  = 750_000,
    parameter int PROG_TICKS = 4,
    parameter int INIT_LIMIT = 1000,
    parameter int ATTEMPTS   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [7:0] byte_data_i,
    input  logic       byte_valid_i,
    input  logic       byte_last_i,
    output logic       byte_ready_o,
    input  logic       init_i,
    output logic       cclk_o,
    output logic       prog_o,
    output logic       din_o,
    output logic [3:0] aux_o,
    output logic       done_o,
    output logic       timeout_o
);
    localparam int DIV = CLK_HZ / UPDATE_HZ;

    logic     tick;
    pin_vec_t pins;

    cfgl_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    cfgl_seq #(
        .PROG_TICKS (PROG_TICKS),
        .INIT_LIMIT (INIT_LIMIT),
        .ATTEMPTS   (ATTEMPTS)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .start_i      (start_i),
        .byte_data_i  (byte_data_i),
        .byte_valid_i (byte_valid_i),
        .byte_last_i  (byte_last_i),
        .byte_ready_o (byte_ready_o),
        .init_i       (init_i),
        .pins_o       (pins),
        .done_o       (done_o),
        .timeout_o    (timeout_o)
    );

    assign cclk_o = pins.cclk;
    assign prog_o = pins.prog;
    assign din_o  = pins.din;
    assign aux_o  = pins.aux;

endmodule

// File: tb/sim_cfg_serial_loader.sv
`timescale 1ns/1ps
module sim_cfg_serial_loader;
    localparam int CLK_HZ = 200_000_000;
    localparam int UPD_HZ = 50_000_000;
    localparam int DIV_T  = CLK_HZ / UPD_HZ;
    localparam int PROG_T = 2;
    localparam int INIT_T = 3;
    localparam int ATT_T  = 2;
    localparam logic [6:0] REST = 7'b1100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [7:0] byte_data_i = 8'h00;
    logic byte_valid_i = 1'b0;
    logic byte_last_i = 1'b0;
    logic byte_ready_o;
    logic init_i = 1'b0;
    logic cclk_o, prog_o, din_o;
    logic [3:0] aux_o;
    logic done_o, timeout_o;

    int checks = 0;
    int fails = 0;
    logic [6:0] exp_v [0:127];
    string      exp_t [0:127];
    int n_exp = 0;

    always #2.5 clk = ~clk;

    cfg_serial_loader #(
        .CLK_HZ(CLK_HZ), .UPDATE_HZ(UPD_HZ), .PROG_TICKS(PROG_T),
        .INIT_LIMIT(INIT_T), .ATTEMPTS(ATT_T)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .byte_data_i(byte_data_i),
        .byte_valid_i(byte_valid_i), .byte_last_i(byte_last_i),
        .byte_ready_o(byte_ready_o), .init_i(init_i), .cclk_o(cclk_o),
        .prog_o(prog_o), .din_o(din_o), .aux_o(aux_o), .done_o(done_o),
        .timeout_o(timeout_o)
    );

    function automatic logic [6:0] pins_now();
        return {cclk_o, prog_o, din_o, aux_o};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic push(input logic [6:0] v, input string t);
        exp_v[n_exp] = v;
        exp_t[n_exp] = t;
        n_exp++;
    endtask

    task automatic push_kill();
        for (int r = 0; r < 4; r++)
            for (int k = 0; k < 8; k++)
                push({3'b110, (k == 2 || k == 4 || k == 6) ? 4'b1010 : 4'b1001}, "R3");
    endtask

    task automatic push_prog();
        for (int i = 0; i < PROG_T; i++) push(7'b1000000, "R4");
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            push({2'b11, b[i], 4'b0000}, "R7");
            push({2'b01, b[i], 4'b0000}, "R7");
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic capture(input int init_at);
        while (pins_now() != 7'b1101001) @(negedge clk);
        for (int i = 0; i < n_exp; i++) begin
            if (i == init_at) init_i = 1'b1;
            chk(pins_now() == exp_v[i], exp_t[i], 32'(pins_now()), 32'(exp_v[i]));
            repeat (DIV_T / 2) @(negedge clk);
            chk(pins_now() == exp_v[i], "R10", 32'(pins_now()), 32'(exp_v[i]));
            repeat (DIV_T - DIV_T / 2) @(negedge clk);
        end
    endtask

    task automatic feed(input logic [7:0] a, input logic [7:0] b, input int n, input bit poke);
        for (int k = 0; k < n; k++) begin
            byte_data_i  = (k == 0) ? a : b;
            byte_last_i  = (k == n - 1);
            byte_valid_i = 1'b1;
            while (!byte_ready_o) @(negedge clk);
            @(negedge clk);
            byte_valid_i = 1'b0;
            if (poke && k == 0) begin
                repeat (10) @(negedge clk);
                pulse_start();  // R2: ignored while busy
            end
        end
        byte_last_i = 1'b0;
    endtask

    task automatic test_reset();
        chk(pins_now() == REST, "R1", 32'(pins_now()), 32'(REST));
        chk(done_o == 1'b0, "R1", 32'(done_o), 0);
        chk(timeout_o == 1'b0, "R1", 32'(timeout_o), 0);
        chk(byte_ready_o == 1'b0, "R1", 32'(byte_ready_o), 0);
    endtask

    task automatic test_clean_load();
        init_i = 1'b1;
        n_exp = 0;
        push_kill(); push_prog();
        push(REST, "R5"); push(REST, "R8");
        push_byte(8'hA5); push(REST, "R8"); push_byte(8'h3C);
        push(REST, "R9"); push(REST, "R9");
        pulse_start();
        fork
            capture(-1);
            feed(8'hA5, 8'h3C, 2, 1'b0);
        join
        chk(done_o == 1'b1, "R9", 32'(done_o), 1);
        chk(timeout_o == 1'b0, "R9", 32'(timeout_o), 0);
    endtask

    task automatic test_timeout();
        init_i = 1'b0;
        n_exp = 0;
        for (int a = 0; a < ATT_T; a++) begin
            push_kill(); push_prog();
            for (int w = 0; w < INIT_T; w++) push(REST, "R5");
        end
        push(REST, "R6"); push(REST, "R6");
        pulse_start();
        chk(done_o == 1'b0, "R2", 32'(done_o), 0);
        capture(-1);
        chk(timeout_o == 1'b1, "R6", 32'(timeout_o), 1);
        chk(done_o == 1'b0, "R6", 32'(done_o), 0);
        chk(byte_ready_o == 1'b0, "R8", 32'(byte_ready_o), 0);
    endtask

    task automatic test_retry_ok();
        init_i = 1'b0;
        n_exp = 0;
        push_kill(); push_prog();
        for (int w = 0; w < INIT_T; w++) push(REST, "R6");
        push_kill(); push_prog();
        push(REST, "R5"); push(REST, "R8");
        push_byte(8'h81);
        push(REST, "R9"); push(REST, "R9");
        pulse_start();
        chk(timeout_o == 1'b0, "R2", 32'(timeout_o), 0);
        fork
            capture(40);
            feed(8'h81, 8'h00, 1, 1'b1);
        join
        chk(done_o == 1'b1, "R9", 32'(done_o), 1);
        chk(timeout_o == 1'b0, "R6", 32'(timeout_o), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_clean_load();
        test_timeout();
        test_retry_ok();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule